// File: doc/BRIEF.md
# Single-Cycle Register/Memory Execution Datapath

This block is the execute half of a small 32-bit processor in which every instruction finishes in one clock. It receives a 32-bit instruction word together with already-decoded control lines. It reads two source registers, forms the second operand from a register or from an extended 16-bit immediate, and computes an add, subtract or OR. On the next clock edge it writes a result into the register file, into a word-addressed data memory, or into neither. Instruction fetch and decoding are outside the block. A separate next-address unit reads the equality flag that the block drives.

The supported instructions are add, subtract, OR with an immediate, load word, store word and the compare for branch-if-equal. The source registers come from instruction bits 25:21 (first) and 20:16 (second). The destination comes from bits 15:11 or bits 20:16. The immediate is bits 15:0. Bits 31:26 are not decoded here. Register reads and memory reads are combinational. The register file and the memory change state only on the rising clock edge.

Top module: `sc_datapath`

## Requirements
- R1: `alu_out` is A+B for `alu_ctl`=00 or 11, A-B for 01, and A|B for 10. A is the register at instr[25:21]. B is the second operand.
- R2: With `alu_src`=0, B is the register at instr[20:16]. With `alu_src`=1, B is instr[15:0], sign-extended when `ext_sign`=1 and zero-extended when `ext_sign`=0.
- R3: `equal_o` is 1 exactly when `alu_out` is zero. With `alu_ctl`=01 and `alu_src`=0 it therefore reports that the two source registers hold the same value.
- R4: When `reg_wr`=1, the rising edge writes `wb_data` into the register at instr[15:11] if `reg_dst`=1, or at instr[20:16] if `reg_dst`=0.
- R5: Register 0 always reads as zero. A write aimed at it has no effect.
- R6: When `mem_wr`=1, the rising edge stores the register at instr[20:16] into memory word `alu_out[9:2]`. `wb_data` is the memory word at `alu_out[9:2]` when `mem_to_reg`=1, and `alu_out` otherwise.
- R7: A read of a register or memory word in the same cycle as a write to it returns the old value. The new value is visible from the cycle after the edge.
- R8: Synchronous active-high `rst` clears all registers to zero. It does not clear the data memory.
- R9: With `reg_wr`=0 no register changes. With `mem_wr`=0 no memory word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the register file |
| instr | input | 32 | Instruction word supplying register numbers and immediate |
| reg_dst | input | 1 | Destination select: 1 = bits 15:11, 0 = bits 20:16 |
| reg_wr | input | 1 | Register write enable |
| ext_sign | input | 1 | Immediate extension: 1 = sign, 0 = zero |
| alu_src | input | 1 | Second operand: 1 = immediate, 0 = register |
| alu_ctl | input | 2 | Operation: 00 add, 01 subtract, 10 OR, 11 add |
| mem_wr | input | 1 | Data memory write enable |
| mem_to_reg | input | 1 | Write-back source: 1 = memory, 0 = ALU |
| equal_o | output | 1 | ALU result is zero |
| alu_out | output | 32 | ALU result, also the memory byte address |
| wb_data | output | 32 | Value presented for register write-back |

## Verification
Within one instruction, a register can be both read and written. An add whose destination is also a source shows this, and so does an immediate OR into its own base register. The bench runs these cases and expects the outputs in that cycle to use the old value, with the updated value showing up on a later read. The memory has the same case when a store is followed directly by a load to the same word, and when a store's address register is itself the data register. The bench compares every such cycle against its own reference register file and memory. Separately, bound properties check that the stored word and the written register read back one cycle later.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_OR   = 2'b10,
    ALU_ADDX = 2'b11
  } alu_op_e;

  localparam int SRC_A_HI = 25;
  localparam int SRC_A_LO = 21;
  localparam int SRC_B_HI = 20;
  localparam int SRC_B_LO = 16;
  localparam int DST_R_HI = 15;
  localparam int DST_R_LO = 11;
  localparam int IMM_HI   = 15;
  localparam int IMM_LO   = 0;
endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int AW     = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     ra,
  input  logic [AW-1:0]     rb,
  output logic [DATA_W-1:0] qa,
  output logic [DATA_W-1:0] qb
);
  logic [DATA_W-1:0] regs [REG_CNT];

  // entry 0 is cleared by reset and never written
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/sc_extend.sv
module sc_extend #(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              sign_en,
  output logic [DATA_W-1:0] ext
);
  localparam int PAD_W = DATA_W - IMM_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign ext = {{PAD_W{sign_en & imm[IMM_W-1]}}, imm};
    end else begin : g_nopad
      assign ext = imm[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        op,
  output logic [DATA_W-1:0] y,
  output logic              zero
);
  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  always_comb begin
    unique case (op_e)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 256,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_CNT   = 32,
  parameter int MEM_WORDS = 256,
  parameter int IMM_W     = 16,
  localparam int RAW      = $clog2(REG_CNT),
  localparam int MAW      = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       instr,
  input  logic              reg_dst,
  input  logic              reg_wr,
  input  logic              ext_sign,
  input  logic              alu_src,
  input  logic [1:0]        alu_ctl,
  input  logic              mem_wr,
  input  logic              mem_to_reg,
  output logic              equal_o,
  output logic [DATA_W-1:0] alu_out,
  output logic [DATA_W-1:0] wb_data
);
  logic [RAW-1:0]    src_a, src_b, dst_r, wr_idx;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] bus_a, bus_b, imm_ext, opnd_b, mem_rdata;
  logic              unused_op;

  assign src_a     = instr[SRC_A_HI:SRC_A_LO];
  assign src_b     = instr[SRC_B_HI:SRC_B_LO];
  assign dst_r     = instr[DST_R_HI:DST_R_LO];
  assign imm       = instr[IMM_HI:IMM_LO];
  assign unused_op = ^instr[31:26];

  assign wr_idx = reg_dst ? dst_r : src_b;

  sc_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) i_rf (
    .clk(clk), .rst(rst), .we(reg_wr), .waddr(wr_idx), .wdata(wb_data),
    .ra(src_a), .rb(src_b), .qa(bus_a), .qb(bus_b)
  );

  sc_extend #(.IMM_W(IMM_W), .DATA_W(DATA_W)) i_ext (
    .imm(imm), .sign_en(ext_sign), .ext(imm_ext)
  );

  assign opnd_b = alu_src ? imm_ext : bus_b;

  sc_alu #(.DATA_W(DATA_W)) i_alu (
    .a(bus_a), .b(opnd_b), .op(alu_ctl), .y(alu_out), .zero(equal_o)
  );

  sc_dmem #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) i_dm (
    .clk(clk), .we(mem_wr), .addr(alu_out[MAW+1:2]), .wdata(bus_b),
    .rdata(mem_rdata)
  );

  assign wb_data = mem_to_reg ? mem_rdata : alu_out;
endmodule

// File: rtl/sc_datapath_chk.sv
module sc_datapath_chk #(
  parameter int DATA_W = 32,
  parameter int RAW    = 5,
  parameter int MAW    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       instr,
  input logic              reg_wr,
  input logic              mem_wr,
  input logic              alu_src,
  input logic [1:0]        alu_ctl,
  input logic              equal_o,
  input logic [RAW-1:0]    wr_idx,
  input logic [DATA_W-1:0] bus_a,
  input logic [DATA_W-1:0] bus_b,
  input logic [DATA_W-1:0] alu_out,
  input logic [DATA_W-1:0] wb_data,
  input logic [DATA_W-1:0] mem_rdata
);
  p_r0_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == '0) |-> (bus_a == '0));

  p_equal_cmp_r3: assert property (@(posedge clk) disable iff (rst)
    (alu_ctl == 2'b01 && !alu_src) |-> (equal_o == (bus_a == bus_b)));

  p_reg_write_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(reg_wr) && $past(wr_idx) != '0 &&
     instr[25:21] == $past(wr_idx)) |-> (bus_a == $past(wb_data)));

  p_store_read_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(mem_wr) &&
     alu_out[MAW+1:2] == $past(alu_out[MAW+1:2])) |-> (mem_rdata == $past(bus_b)));

  p_reg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!reg_wr) && $stable(instr)) |-> $stable(bus_a));

  p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!mem_wr) && $stable(alu_out)) |-> $stable(mem_rdata));
endmodule

bind sc_datapath sc_datapath_chk #(.DATA_W(DATA_W), .RAW(RAW), .MAW(MAW)) i_chk (
  .clk(clk), .rst(rst), .instr(instr), .reg_wr(reg_wr), .mem_wr(mem_wr),
  .alu_src(alu_src), .alu_ctl(alu_ctl), .equal_o(equal_o), .wr_idx(wr_idx),
  .bus_a(bus_a), .bus_b(bus_b), .alu_out(alu_out), .wb_data(wb_data),
  .mem_rdata(mem_rdata)
);

// File: tb/test_sc_datapath.sv
module test_sc_datapath;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic        reg_dst = 0, reg_wr = 0, ext_sign = 0, alu_src = 0;
  logic [1:0]  alu_ctl = 2'b00;
  logic        mem_wr = 0, mem_to_reg = 0;
  logic        equal_o;
  logic [31:0] alu_out, wb_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] m_rf  [32];
  logic [31:0] m_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_datapath i_sc_datapath (
    .clk(clk), .rst(rst), .instr(instr), .reg_dst(reg_dst), .reg_wr(reg_wr),
    .ext_sign(ext_sign), .alu_src(alu_src), .alu_ctl(alu_ctl), .mem_wr(mem_wr),
    .mem_to_reg(mem_to_reg), .equal_o(equal_o), .alu_out(alu_out), .wb_data(wb_data)
  );

  function automatic logic [31:0] f_ext(input logic [15:0] imm, input logic sx);
    return sx ? {{16{imm[15]}}, imm} : {16'h0, imm};
  endfunction

  function automatic logic [31:0] f_alu(input logic [31:0] a, b, input logic [1:0] op);
    case (op)
      2'b01:   return a - b;
      2'b10:   return a | b;
      default: return a + b;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic exec(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm,
                      input logic rdst, input logic rw, input logic sx, input logic asrc,
                      input logic [1:0] op, input logic mw, input logic m2r, input string tag);
    logic [31:0] a, b, res, wb;
    logic [4:0]  dst;
    @(negedge clk);
    instr = {6'h0, rs, rt, imm};
    reg_dst = rdst; reg_wr = rw; ext_sign = sx; alu_src = asrc;
    alu_ctl = op; mem_wr = mw; mem_to_reg = m2r;
    a   = m_rf[rs];
    b   = asrc ? f_ext(imm, sx) : m_rf[rt];
    res = f_alu(a, b, op);
    wb  = m2r ? m_mem[res[9:2]] : res;
    dst = rdst ? imm[15:11] : rt;
    #1;
    check(tag, "alu_out", alu_out, res);
    check(tag, "equal_o", {31'h0, equal_o}, {31'h0, res == 32'h0});
    check(tag, "wb_data", wb_data, wb);
    @(posedge clk);
    if (rw && dst != 5'd0) m_rf[dst] = wb;
    if (mw) m_mem[res[9:2]] = m_rf[rt];
  endtask

  task automatic t_add(input logic [4:0] rd, rs, rt, input string tag);
    exec(rs, rt, {rd, 11'h0}, 1, 1, 0, 0, 2'b00, 0, 0, tag);
  endtask
  task automatic t_sub(input logic [4:0] rd, rs, rt, input string tag);
    exec(rs, rt, {rd, 11'h0}, 1, 1, 0, 0, 2'b01, 0, 0, tag);
  endtask
  task automatic t_ori(input logic [4:0] rt, rs, input logic [15:0] imm, input string tag);
    exec(rs, rt, imm, 0, 1, 0, 1, 2'b10, 0, 0, tag);
  endtask
  task automatic t_lw(input logic [4:0] rt, rs, input logic [15:0] imm, input string tag);
    exec(rs, rt, imm, 0, 1, 1, 1, 2'b00, 0, 1, tag);
  endtask
  task automatic t_sw(input logic [4:0] rt, rs, input logic [15:0] imm, input string tag);
    exec(rs, rt, imm, 0, 0, 1, 1, 2'b00, 1, 0, tag);
  endtask
  task automatic t_beq(input logic [4:0] rs, rt, input string tag);
    exec(rs, rt, 16'h0, 0, 0, 0, 0, 2'b01, 0, 0, tag);
  endtask
  task automatic t_peek(input logic [4:0] r, input string tag);
    exec(r, 5'd0, 16'h0, 0, 0, 0, 1, 2'b10, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R8: every register reads zero after reset
    for (int r = 0; r < 32; r++) t_peek(5'(r), "R8");

    // seed registers with small OR-immediate values
    for (int r = 1; r < 32; r++) t_ori(5'(r), 5'd0, 16'($urandom), "R2");
    // fill memory through stores based on r0 (R6)
    for (int w = 0; w < 256; w++)
      t_sw(5'((w % 31) + 1), 5'd0, 16'(w * 4), "R6");

    // R2: sign vs zero extension of a negative immediate
    t_ori(5'd3, 5'd0, 16'h8001, "R2");
    t_peek(5'd3, "R2");
    exec(5'd0, 5'd4, 16'hFFFC, 0, 1, 1, 1, 2'b00, 0, 0, "R2");
    t_peek(5'd4, "R2");

    // R1: each operation, including the alternate add code 11
    t_add(5'd5, 5'd1, 5'd2, "R1");
    t_sub(5'd6, 5'd1, 5'd2, "R1");
    exec(5'd1, 5'd2, {5'd7, 11'h0}, 1, 1, 0, 0, 2'b11, 0, 0, "R1");
    t_peek(5'd7, "R1");

    // R4: reg_dst picks bits 15:11 vs bits 20:16
    exec(5'd1, 5'd9, {5'd10, 11'h0}, 1, 1, 0, 0, 2'b00, 0, 0, "R4");
    t_peek(5'd9, "R4");
    t_peek(5'd10, "R4");
    exec(5'd1, 5'd11, 16'h0020, 0, 1, 0, 1, 2'b10, 0, 0, "R4");
    t_peek(5'd11, "R4");

    // R5: write to r0 is discarded
    t_ori(5'd0, 5'd1, 16'h1234, "R5");
    t_peek(5'd0, "R5");
    t_add(5'd0, 5'd1, 5'd2, "R5");
    t_beq(5'd0, 5'd0, "R5");

    // R3: compare equal and unequal
    t_ori(5'd12, 5'd0, 16'h55AA, "R3");
    t_ori(5'd13, 5'd0, 16'h55AA, "R3");
    t_beq(5'd12, 5'd13, "R3");
    t_ori(5'd13, 5'd0, 16'h55AB, "R3");
    t_beq(5'd12, 5'd13, "R3");

    // R7: same-cycle read of the register being written
    t_add(5'd14, 5'd14, 5'd14, "R7");
    t_add(5'd14, 5'd14, 5'd14, "R7");
    t_peek(5'd14, "R7");
    t_ori(5'd15, 5'd0, 16'h0100, "R7");
    t_sw(5'd15, 5'd15, 16'h0004, "R7");
    t_lw(5'd16, 5'd15, 16'h0004, "R7");
    t_sw(5'd12, 5'd15, 16'h0004, "R7");
    t_lw(5'd15, 5'd15, 16'h0004, "R7");
    t_peek(5'd15, "R7");

    // R6: load with negative offset, store then load back
    t_ori(5'd17, 5'd0, 16'h0040, "R6");
    t_sw(5'd13, 5'd17, 16'hFFF8, "R6");
    t_lw(5'd18, 5'd17, 16'hFFF8, "R6");
    t_peek(5'd18, "R6");

    // R9: store-shaped cycle with mem_wr=0 and add with reg_wr=0
    exec(5'd17, 5'd1, 16'h0000, 0, 0, 1, 1, 2'b00, 0, 0, "R9");
    t_lw(5'd19, 5'd17, 16'h0000, "R9");
    exec(5'd1, 5'd2, {5'd20, 11'h0}, 1, 0, 0, 0, 2'b00, 0, 0, "R9");
    t_peek(5'd20, "R9");

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [4:0] ra, rb, rc;
      logic [15:0] im;
      ra = 5'($urandom); rb = 5'($urandom); rc = 5'($urandom);
      im = 16'($urandom);
      case ($urandom % 6)
        0: t_add(rc, ra, rb, "R1");
        1: t_sub(rc, ra, rb, "R1");
        2: t_ori(rb, ra, im, "R2");
        3: t_lw(rb, ra, im, "R6");
        4: t_sw(rb, ra, im, "R6");
        default: t_beq(ra, ($urandom % 4 == 0) ? ra : rb, "R3");
      endcase
    end

    // R8: reset clears registers again
    @(negedge clk); rst = 1;
    reg_wr = 0; mem_wr = 0;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    for (int r = 0; r < 32; r += 5) t_peek(5'(r), "R8");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule